// File: doc/BRIEF.md
# ECC and Parity Error Injector

This block sits on the outgoing side of two packet channels, one carrying read traffic and one carrying write traffic. Each beat carries a wide protected word (182 bits by default) and a separate parity bit. On request the block inverts chosen bits of a beat on its way out. A downstream ECC or parity checker then meets a known fault and can be tested. The valid/ready handshake of each channel passes straight through. Only the data and parity of a beat may change.

One 32-bit control word sets the injection. It holds two bit positions, a mode bit, and four arm/flag pairs: ECC read, ECC write, parity read and parity write. A full-word write port loads the word and a read port returns it. In one-shot mode an armed source corrupts exactly one accepted beat and then raises its flag. In persistent mode an armed source corrupts every accepted beat. The block does not generate or check ECC.

Top module: `ecc_inj_top`

## Requirements
- R1: After reset the control word reads back as 0x00000000, and beats pass through unchanged.
- R2: A write stores bits 24:0 exactly as written. Bits 31:25 always read as zero, whatever was written to them.
- R3: The control word has two position fields, A at bits 7:0 and B at bits 15:8. When an armed ECC source injects and A equals B, exactly that one data bit of the beat is inverted.
- R4: When an ECC source injects and A differs from B, and both are below 182, exactly the two addressed data bits are inverted.
- R5: Bit 24 selects the mode, with 0 meaning one-shot. In one-shot mode an armed source corrupts the first accepted beat on its channel. Its flag is then set from the next cycle on, and later beats pass unchanged while that flag stays set. The sources, their arm bits and their flag bits are: ECC read, arm 16, flag 17; ECC write, arm 18, flag 19; parity read, arm 20, flag 21; parity write, arm 22, flag 23.
- R6: A one-shot source fires again only after software clears both its arm and flag bits and then sets the arm bit again. Rewriting the arm bit while the flag is still set causes no injection.
- R7: With bit 24 set, every accepted beat on the channel of an armed source is corrupted, and the source's flag is set after the first such beat.
- R8: A parity source inverts only the parity bit of its own channel and leaves the data unchanged. A source never touches the other channel.
- R9: A beat is accepted only when valid and ready are both high. A beat that is not accepted is never corrupted and does not use up a one-shot injection.
- R10: A position value of 182 or more inverts no bit for that field. The source's flag is still set as if an injection had taken place.
- R11: When the hardware sets a flag in the same cycle as a software write that clears it, the flag ends up set.
- R12: Each downstream valid equals its upstream valid, and each upstream ready equals its downstream ready, in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Full-word write strobe for the control word |
| cfg_wr_data | input | 32 | Control word write value |
| cfg_rd_data | output | 32 | Current control word |
| rd_up_valid | input | 1 | Read channel, beat valid from upstream |
| rd_up_data | input | 182 | Read channel, protected word from upstream |
| rd_up_par | input | 1 | Read channel, parity bit from upstream |
| rd_up_ready | output | 1 | Read channel, ready back to upstream |
| rd_dn_valid | output | 1 | Read channel, beat valid to downstream |
| rd_dn_data | output | 182 | Read channel, protected word to downstream |
| rd_dn_par | output | 1 | Read channel, parity bit to downstream |
| rd_dn_ready | input | 1 | Read channel, ready from downstream |
| wr_up_valid | input | 1 | Write channel, beat valid from upstream |
| wr_up_data | input | 182 | Write channel, protected word from upstream |
| wr_up_par | input | 1 | Write channel, parity bit from upstream |
| wr_up_ready | output | 1 | Write channel, ready back to upstream |
| wr_dn_valid | output | 1 | Write channel, beat valid to downstream |
| wr_dn_data | output | 182 | Write channel, protected word to downstream |
| wr_dn_par | output | 1 | Write channel, parity bit to downstream |
| wr_dn_ready | input | 1 | Write channel, ready from downstream |

## Verification
Data, parity and handshake outputs are combinational. They are due in the same cycle the beat is presented. Flag bits and written fields appear on the read port one cycle later, after the next rising edge. The driver applies each beat on a falling edge and pushes the predicted outputs into a queue. The monitor compares them 1 ns later, still before the next rising edge. Control-word checks are made at the falling edge after the one that launched the beat or write, so the single register stage has settled.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
   localparam int CTRL_W    = 32;
   localparam int FIELD_W   = 8;
   localparam int NUM_SRC   = 4;
   localparam int POS_A_LSB = 0;
   localparam int POS_B_LSB = 8;
   localparam int ARM_LSB   = 16;
   localparam int MODE_BIT  = 24;
   localparam int USED_W    = 25;

   // Source index; odd sources live on the write channel.
   typedef enum logic [1:0] {
      SRC_ECC_RD = 2'd0,
      SRC_ECC_WR = 2'd1,
      SRC_PAR_RD = 2'd2,
      SRC_PAR_WR = 2'd3
   } inj_src_e;
endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
   import ecc_inj_pkg::*;
#(
   parameter int NSRC = NUM_SRC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CTRL_W-1:0]   wr_data,
   input  logic [NSRC-1:0]     hw_done_set,
   output logic [CTRL_W-1:0]   rd_data,
   output logic [NSRC-1:0]     arm,
   output logic [NSRC-1:0]     done,
   output logic                persist,
   output logic [FIELD_W-1:0]  pos_a,
   output logic [FIELD_W-1:0]  pos_b
);
   localparam int TOP_PAIR = ARM_LSB + 2*NSRC;

   generate
      if (TOP_PAIR > MODE_BIT) begin : g_bad_nsrc
         $error("ecc_inj_regs: arm/flag pairs overlap the mode bit");
      end
   endgenerate

   logic [FIELD_W-1:0] pos_a_q, pos_b_q;
   logic               persist_q;
   logic [NSRC-1:0]    arm_q, done_q;
   logic               unused_resv;

   assign unused_resv = ^wr_data[CTRL_W-1:USED_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_a_q   <= '0;
         pos_b_q   <= '0;
         persist_q <= 1'b0;
      end else if (wr_en) begin
         pos_a_q   <= wr_data[POS_A_LSB +: FIELD_W];
         pos_b_q   <= wr_data[POS_B_LSB +: FIELD_W];
         persist_q <= wr_data[MODE_BIT];
      end
   end

   genvar s;
   generate
      for (s = 0; s < NSRC; s++) begin : g_pair
         localparam int AB = ARM_LSB + 2*s;
         localparam int DB = ARM_LSB + 2*s + 1;

         always_ff @(posedge clk) begin
            if (!rst_n)     arm_q[s] <= 1'b0;
            else if (wr_en) arm_q[s] <= wr_data[AB];
         end

         // hardware set outranks a software write in the same cycle
         always_ff @(posedge clk) begin
            if (!rst_n)              done_q[s] <= 1'b0;
            else if (hw_done_set[s]) done_q[s] <= 1'b1;
            else if (wr_en)          done_q[s] <= wr_data[DB];
         end

         a_r11_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
            hw_done_set[s] |=> done_q[s]);
         a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (done_q[s] && !wr_en) |=> done_q[s]);
         a_r6_sw_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[DB] && !hw_done_set[s]) |=> !done_q[s]);
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      rd_data[POS_A_LSB +: FIELD_W] = pos_a_q;
      rd_data[POS_B_LSB +: FIELD_W] = pos_b_q;
      rd_data[MODE_BIT]             = persist_q;
      for (int k = 0; k < NSRC; k++) begin
         rd_data[ARM_LSB + 2*k]     = arm_q[k];
         rd_data[ARM_LSB + 2*k + 1] = done_q[k];
      end
   end

   assign arm     = arm_q;
   assign done    = done_q;
   assign persist = persist_q;
   assign pos_a   = pos_a_q;
   assign pos_b   = pos_b_q;
endmodule

// File: rtl/ecc_inj_gate.sv
module ecc_inj_gate #(
   parameter bit ALLOW_PERSIST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic done,
   input  logic persist,
   input  logic beat,
   output logic fire,
   output logic hw_set
);
   logic live;

   generate
      if (ALLOW_PERSIST) begin : g_both_modes
         assign live = arm & (persist | ~done);
      end else begin : g_one_shot
         logic unused_mode;
         assign unused_mode = persist;
         assign live = arm & ~done;
      end
   endgenerate

   assign fire   = live & beat;
   assign hw_set = fire;

   a_r5_one_shot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && done && !persist) |-> !fire);
   a_r9_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
      !beat |-> !fire);
   generate
      if (ALLOW_PERSIST) begin : g_chk_persist
         a_r7_every_beat: assert property (@(posedge clk) disable iff (!rst_n)
            (arm && persist && beat) |-> fire);
      end
   endgenerate
endmodule

// File: rtl/ecc_inj_lane.sv
module ecc_inj_lane
   import ecc_inj_pkg::*;
#(
   parameter int DATA_W   = 182,
   parameter bit DUAL_POS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               up_valid,
   input  logic [DATA_W-1:0]  up_data,
   input  logic               up_par,
   output logic               up_ready,
   output logic               dn_valid,
   output logic [DATA_W-1:0]  dn_data,
   output logic               dn_par,
   input  logic               dn_ready,
   input  logic               ecc_fire,
   input  logic               par_fire,
   input  logic [FIELD_W-1:0] pos_a,
   input  logic [FIELD_W-1:0] pos_b,
   output logic               beat
);
   generate
      if (DATA_W > (1 << FIELD_W)) begin : g_bad_width
         $error("ecc_inj_lane: DATA_W exceeds what a position field can address");
      end
   endgenerate

   logic [DATA_W-1:0] mask;

   genvar i;
   generate
      for (i = 0; i < DATA_W; i++) begin : g_bit
         if (DUAL_POS) begin : g_two
            assign mask[i] = (pos_a == FIELD_W'(i)) | (pos_b == FIELD_W'(i));
         end else begin : g_one
            assign mask[i] = (pos_a == FIELD_W'(i));
         end
      end
      if (!DUAL_POS) begin : g_unused_b
         logic unused_pos_b;
         assign unused_pos_b = ^pos_b;
      end
   endgenerate

   assign dn_valid = up_valid;
   assign up_ready = dn_ready;
   assign beat     = up_valid & dn_ready;
   assign dn_data  = up_data ^ (ecc_fire ? mask : '0);
   assign dn_par   = up_par ^ par_fire;

   a_r9_clean_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !beat |-> (dn_data == up_data && dn_par == up_par));
   a_r8_parity_only: assert property (@(posedge clk) disable iff (!rst_n)
      (par_fire && !ecc_fire) |-> (dn_data == up_data && dn_par != up_par));
   a_r3_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_fire && pos_a == pos_b && int'(pos_a) < DATA_W)
         |-> $countones(dn_data ^ up_data) == 1);
   generate
      if (DUAL_POS) begin : g_chk_dual
         a_r4_double_flip: assert property (@(posedge clk) disable iff (!rst_n)
            (ecc_fire && pos_a != pos_b && int'(pos_a) < DATA_W && int'(pos_b) < DATA_W)
               |-> $countones(dn_data ^ up_data) == 2);
      end
   endgenerate
   a_r10_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(pos_a) >= DATA_W && int'(pos_b) >= DATA_W) |-> dn_data == up_data);
endmodule

// File: rtl/ecc_inj_top.sv
module ecc_inj_top
   import ecc_inj_pkg::*;
#(
   parameter int DATA_W        = 182,
   parameter bit ALLOW_PERSIST = 1'b1,
   parameter bit DUAL_POS      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr_en,
   input  logic [CTRL_W-1:0]  cfg_wr_data,
   output logic [CTRL_W-1:0]  cfg_rd_data,
   input  logic               rd_up_valid,
   input  logic [DATA_W-1:0]  rd_up_data,
   input  logic               rd_up_par,
   output logic               rd_up_ready,
   output logic               rd_dn_valid,
   output logic [DATA_W-1:0]  rd_dn_data,
   output logic               rd_dn_par,
   input  logic               rd_dn_ready,
   input  logic               wr_up_valid,
   input  logic [DATA_W-1:0]  wr_up_data,
   input  logic               wr_up_par,
   output logic               wr_up_ready,
   output logic               wr_dn_valid,
   output logic [DATA_W-1:0]  wr_dn_data,
   output logic               wr_dn_par,
   input  logic               wr_dn_ready
);
   logic [NUM_SRC-1:0] arm, done, fire, hw_set;
   logic               persist;
   logic [FIELD_W-1:0] pos_a, pos_b;
   logic               rd_beat, wr_beat;

   ecc_inj_regs #(.NSRC(NUM_SRC)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (cfg_wr_en),
      .wr_data     (cfg_wr_data),
      .hw_done_set (hw_set),
      .rd_data     (cfg_rd_data),
      .arm         (arm),
      .done        (done),
      .persist     (persist),
      .pos_a       (pos_a),
      .pos_b       (pos_b)
   );

   genvar s;
   generate
      for (s = 0; s < NUM_SRC; s++) begin : g_src
         localparam bit ON_WR = (s % 2) == 1;
         ecc_inj_gate #(.ALLOW_PERSIST(ALLOW_PERSIST)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm     (arm[s]),
            .done    (done[s]),
            .persist (persist),
            .beat    (ON_WR ? wr_beat : rd_beat),
            .fire    (fire[s]),
            .hw_set  (hw_set[s])
         );
      end
   endgenerate

   ecc_inj_lane #(.DATA_W(DATA_W), .DUAL_POS(DUAL_POS)) u_rd_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (rd_up_valid),
      .up_data  (rd_up_data),
      .up_par   (rd_up_par),
      .up_ready (rd_up_ready),
      .dn_valid (rd_dn_valid),
      .dn_data  (rd_dn_data),
      .dn_par   (rd_dn_par),
      .dn_ready (rd_dn_ready),
      .ecc_fire (fire[int'(SRC_ECC_RD)]),
      .par_fire (fire[int'(SRC_PAR_RD)]),
      .pos_a    (pos_a),
      .pos_b    (pos_b),
      .beat     (rd_beat)
   );

   ecc_inj_lane #(.DATA_W(DATA_W), .DUAL_POS(DUAL_POS)) u_wr_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (wr_up_valid),
      .up_data  (wr_up_data),
      .up_par   (wr_up_par),
      .up_ready (wr_up_ready),
      .dn_valid (wr_dn_valid),
      .dn_data  (wr_dn_data),
      .dn_par   (wr_dn_par),
      .dn_ready (wr_dn_ready),
      .ecc_fire (fire[int'(SRC_ECC_WR)]),
      .par_fire (fire[int'(SRC_PAR_WR)]),
      .pos_a    (pos_a),
      .pos_b    (pos_b),
      .beat     (wr_beat)
   );

   a_r8_channels_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_beat |-> !(fire[int'(SRC_ECC_RD)] || fire[int'(SRC_PAR_RD)]));
endmodule

// File: tb/ecc_inj_top_tb_top.sv
module ecc_inj_top_tb_top;
   localparam int W = 182;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          cfg_wr_en = 1'b0;
   logic [31:0]   cfg_wr_data = '0;
   logic [31:0]   cfg_rd_data;
   logic          rd_up_valid = 1'b0, rd_up_par = 1'b0, rd_dn_ready = 1'b0;
   logic [W-1:0]  rd_up_data = '0;
   logic          rd_up_ready, rd_dn_valid, rd_dn_par;
   logic [W-1:0]  rd_dn_data;
   logic          wr_up_valid = 1'b0, wr_up_par = 1'b0, wr_dn_ready = 1'b0;
   logic [W-1:0]  wr_up_data = '0;
   logic          wr_up_ready, wr_dn_valid, wr_dn_par;
   logic [W-1:0]  wr_dn_data;

   ecc_inj_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
      .rd_up_valid(rd_up_valid), .rd_up_data(rd_up_data), .rd_up_par(rd_up_par),
      .rd_up_ready(rd_up_ready), .rd_dn_valid(rd_dn_valid), .rd_dn_data(rd_dn_data),
      .rd_dn_par(rd_dn_par), .rd_dn_ready(rd_dn_ready),
      .wr_up_valid(wr_up_valid), .wr_up_data(wr_up_data), .wr_up_par(wr_up_par),
      .wr_up_ready(wr_up_ready), .wr_dn_valid(wr_dn_valid), .wr_dn_data(wr_dn_data),
      .wr_dn_par(wr_dn_par), .wr_dn_ready(wr_dn_ready)
   );

   typedef struct {
      int           ch;
      bit           v;
      bit           r;
      logic [W-1:0] d;
      logic         p;
      string        req;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad = 0;

   // reference model of the control word
   bit       m_en[4];
   bit       m_done[4];
   bit       m_pers;
   bit [7:0] m_pa, m_pb;

   function automatic logic [31:0] model_word();
      logic [31:0] w = '0;
      w[7:0]  = m_pa;
      w[15:8] = m_pb;
      w[24]   = m_pers;
      for (int k = 0; k < 4; k++) begin
         w[16 + 2*k] = m_en[k];
         w[17 + 2*k] = m_done[k];
      end
      return w;
   endfunction

   function automatic logic [W-1:0] flip_mask(bit [7:0] a, bit [7:0] b);
      logic [W-1:0] m = '0;
      for (int i = 0; i < W; i++)
         if (a == 8'(i) || b == 8'(i)) m[i] = 1'b1;
      return m;
   endfunction

   task automatic beat(input int ch, input bit v, input bit r,
                       input bit wr, input logic [31:0] wd, input string req);
      logic [191:0] t;
      logic [W-1:0] d;
      logic         p;
      bit           qual, fe, fp;
      int           se, sp;
      bit           hw[4];
      item_t        it;
      t = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
      d = t[W-1:0];
      p = 1'($urandom());
      @(negedge clk);
      cfg_wr_en   = wr;
      cfg_wr_data = wd;
      if (ch == 0) begin
         rd_up_valid = v; rd_up_data = d; rd_up_par = p; rd_dn_ready = r;
         wr_up_valid = 1'b0; wr_up_data = '0; wr_up_par = 1'b0; wr_dn_ready = 1'b0;
      end else begin
         wr_up_valid = v; wr_up_data = d; wr_up_par = p; wr_dn_ready = r;
         rd_up_valid = 1'b0; rd_up_data = '0; rd_up_par = 1'b0; rd_dn_ready = 1'b0;
      end
      qual = v && r;
      se = (ch == 0) ? 0 : 1;
      sp = (ch == 0) ? 2 : 3;
      fe = qual && m_en[se] && (m_pers || !m_done[se]);
      fp = qual && m_en[sp] && (m_pers || !m_done[sp]);
      it.ch = ch; it.v = v; it.r = r; it.req = req;
      it.d = fe ? (d ^ flip_mask(m_pa, m_pb)) : d;
      it.p = p ^ fp;
      q.push_back(it);
      for (int k = 0; k < 4; k++) hw[k] = 1'b0;
      hw[se] = fe;
      hw[sp] = fp;
      for (int k = 0; k < 4; k++)
         m_done[k] = hw[k] | (wr ? wd[17 + 2*k] : m_done[k]);
      if (wr) begin
         m_pa = wd[7:0];
         m_pb = wd[15:8];
         m_pers = wd[24];
         for (int k = 0; k < 4; k++) m_en[k] = wd[16 + 2*k];
      end
   endtask

   task automatic wreg(input logic [31:0] wd, input string req);
      beat(0, 1'b0, 1'b0, 1'b1, wd, req);
   endtask

   task automatic chk_reg(input string req);
      logic [31:0] exp_w;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      rd_up_valid = 1'b0; wr_up_valid = 1'b0;
      rd_dn_ready = 1'b0; wr_dn_ready = 1'b0;
      exp_w = model_word();
      #1;
      total++;
      if (cfg_rd_data !== exp_w) begin
         bad++;
         $display("FAIL %s control word: actual=%h expected=%h", req, cfg_rd_data, exp_w);
      end
   endtask

   // monitor: compares queued predictions 1 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [W-1:0] ad;
            logic ap, av, ar;
            it = q.pop_front();
            if (it.ch == 0) begin
               ad = rd_dn_data; ap = rd_dn_par; av = rd_dn_valid; ar = rd_up_ready;
            end else begin
               ad = wr_dn_data; ap = wr_dn_par; av = wr_dn_valid; ar = wr_up_ready;
            end
            total++;
            if (ad !== it.d || ap !== it.p || av !== it.v || ar !== it.r) begin
               bad++;
               $display("FAIL %s ch%0d: actual d=%h p=%b v=%b r=%b expected d=%h p=%b v=%b r=%b",
                        it.req, it.ch, ad, ap, av, ar, it.d, it.p, it.v, it.r);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   localparam logic [31:0] PERS = 32'h0100_0000;
   function automatic logic [31:0] en_b(int s);   return 32'(1) << (16 + 2*s); endfunction
   function automatic logic [31:0] dn_b(int s);   return 32'(1) << (17 + 2*s); endfunction
   function automatic logic [31:0] pos(int a, int b); return {16'h0, 8'(b), 8'(a)}; endfunction

   initial begin
      for (int k = 0; k < 4; k++) begin m_en[k] = 1'b0; m_done[k] = 1'b0; end
      m_pers = 1'b0; m_pa = '0; m_pb = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state and clean pass-through
      chk_reg("R1");
      beat(0, 1, 1, 0, '0, "R1");
      beat(1, 1, 1, 0, '0, "R1");
      // R12: handshake follows through
      beat(0, 0, 1, 0, '0, "R12");
      beat(1, 1, 0, 0, '0, "R12");

      // R2: writable fields and reserved bits
      wreg(32'hFFFF_FFFF, "R2");
      chk_reg("R2");
      wreg(32'h0000_0000, "R2");
      chk_reg("R2");

      // R3/R5/R9: one-shot single-bit on ECC read
      wreg(en_b(0) | pos(5, 5), "R3");
      beat(0, 1, 0, 0, '0, "R9");
      beat(0, 1, 1, 0, '0, "R3");
      chk_reg("R5");
      beat(0, 1, 1, 0, '0, "R5");
      beat(1, 1, 1, 0, '0, "R8");

      // R6/R4: re-arm rules then double-bit
      wreg(en_b(0) | dn_b(0) | pos(3, 100), "R6");
      beat(0, 1, 1, 0, '0, "R6");
      wreg(pos(3, 100), "R6");
      wreg(en_b(0) | pos(3, 100), "R6");
      beat(0, 1, 1, 0, '0, "R4");
      chk_reg("R6");

      // R8: parity on write channel only
      wreg(en_b(3) | pos(9, 9), "R8");
      beat(0, 1, 1, 0, '0, "R8");
      beat(1, 1, 1, 0, '0, "R8");
      chk_reg("R8");
      beat(1, 1, 1, 0, '0, "R8");

      // R7: persistent ECC write at both ends of the word
      wreg(32'h0, "R7");
      wreg(PERS | en_b(1) | pos(0, 181), "R7");
      beat(1, 1, 1, 0, '0, "R7");
      beat(1, 1, 1, 0, '0, "R7");
      beat(1, 1, 0, 0, '0, "R9");
      beat(1, 1, 1, 0, '0, "R7");
      chk_reg("R7");

      // R10: out-of-range positions
      wreg(32'h0, "R10");
      wreg(en_b(0) | pos(190, 200), "R10");
      beat(0, 1, 1, 0, '0, "R10");
      chk_reg("R10");
      wreg(32'h0, "R10");
      wreg(en_b(0) | pos(182, 40), "R10");
      beat(0, 1, 1, 0, '0, "R10");

      // R11: hardware set collides with a clearing write
      wreg(32'h0, "R11");
      wreg(en_b(0) | pos(7, 7), "R11");
      beat(0, 1, 1, 1, en_b(0) | pos(7, 7), "R11");
      chk_reg("R11");
      beat(0, 1, 1, 0, '0, "R11");

      chk_reg("R2");
      @(negedge clk);
      #2;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule